// File: doc/BRIEF.md
# PWM Generator with Global Shadow Load

This block is an up-counting PWM timer. Seven parameters set its waveform: the period, four compare values (A to D) and two dead-band delays, one for the rising edge and one for the falling edge. Each parameter has a shadow copy that software writes and an active copy that drives the waveform. The block drives a complementary pair of outputs with dead time between them. It also gives a one-cycle pulse at each counter zero and a flag that shows a global load is waiting.

The global load controller lets software update several parameters with no risk that a counter-zero event falls in the middle of the update. Software writes the new shadow values, selects the registers that take part through a mask, and then pulses an arm input. Every selected register then copies its shadow value to its active copy on the same clock edge. That edge is the first wrap of the counter to zero after arming. Registers outside the mask keep their own load mode.

A peer write port carries writes made to a neighbouring instance. For each register a link bit decides whether a peer write is copied into this instance's shadow register.

Top module: `pwm_sync_load`

## Requirements
- R1: The counter counts 0, 1, ..., P and then returns to 0, where P is the active period, so one PWM cycle lasts P+1 clocks. `zero_evt` is high for exactly the one clock in which the counter is 0. After reset the counter is 0, `zero_evt` is high, both outputs are low and `load_armed` is low.
- R2: The internal waveform is high while the counter is below the active compare A value. Within a cycle, where index 0 is the `zero_evt` clock, `pwm_a` goes high at index RED+1 and goes low at index CMPA+1. RED is the rising-edge delay that was active at index 0.
- R3: `pwm_b` follows the inverse of the waveform and is never high together with `pwm_a`. It goes high at index CMPA+1+FED, where FED is the falling-edge delay active at index CMPA. It goes low at index 1 of the next cycle.
- R4: The write address map is: 0 period, 1 compare A, 2 compare B, 3 compare C, 4 compare D, 5 rising delay, 6 falling delay, 7 mode register, 8 global register, 9 link register. In the mode register, bit r set means register r is in shadow mode. A shadow-mode register takes its shadow value at the edge where the counter wraps to 0. A write made during a cycle therefore applies from the next cycle.
- R5: The mode register resets to 0x001F, which puts the period and the four compares in shadow mode. The two delays start in immediate mode, where a write reaches the active copy on the edge that captures it.
- R6: If a delay changes while a delayed edge is already counting, that edge completes with the value latched when it started. The new value applies from the next edge.
- R7: In the global register, bits 6:0 are the participation mask and bit 7 enables global mode. While global mode is enabled, a masked-in register never loads without an armed transfer, whatever its mode bit says. Writes to it reach only its shadow copy.
- R8: An arm pulse taken while global mode is enabled sets `load_armed`. At the next wrap to 0, every masked-in register loads its shadow value on the same edge, including the delays together with the period and compares.
- R9: `load_armed` clears on the transfer edge. Arm pulses while already armed have no effect, so a single transfer occurs and nothing is left pending.
- R10: Shadow writes made while armed are accepted. The last value written before the transfer edge is the value transferred.
- R11: While global mode is enabled, registers outside the mask keep their own shadow or immediate behaviour.
- R12: A peer write to register r updates this instance only when bit r of the link register is set. A local write to the same register in the same clock wins.
- R13: An arm pulse while global mode is disabled is ignored, and `load_armed` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Local write strobe |
| wr_addr | input | 4 | Local write address (map in R4) |
| wr_data | input | CW | Local write data |
| peer_wr_en | input | 1 | Write strobe from a peer instance |
| peer_wr_addr | input | 4 | Peer write address (0 to 6 only) |
| peer_wr_data | input | CW | Peer write data |
| gload_arm | input | 1 | One-clock pulse that arms the global load |
| pwm_a | output | 1 | Output A, rising edge delayed |
| pwm_b | output | 1 | Complementary output B, rising edge delayed |
| zero_evt | output | 1 | High in the clock where the counter is 0 |
| load_armed | output | 1 | A global load is pending |

## Verification
Two things can happen on the same clock edge: the global transfer at the counter wrap, and the start of the rising-edge delay, which latches the delay value at index 0. The bench masks the rising delay in together with the period, so the transfer and the start of that delay land on the same wrap edge. It then checks the first new cycle: the new period length and the new rising position must appear together, with no cycle that mixes old and new values. A second collision is an immediate delay write captured on the very edge where a delay starts counting. The bench expects that delay to finish with the old value in the current cycle and to use the new value from the next cycle.

// File: rtl/psl_pkg.sv
`timescale 1ns/1ps
package psl_pkg;
   localparam int NREG = 7;
   localparam int AW   = 4;

   // register indices; order matches the write address map
   localparam int IDX_PRD  = 0;
   localparam int IDX_CMPA = 1;
   localparam int IDX_CMPB = 2;
   localparam int IDX_CMPC = 3;
   localparam int IDX_CMPD = 4;
   localparam int IDX_RED  = 5;
   localparam int IDX_FED  = 6;

   localparam logic [AW-1:0] ADDR_MODE = 4'd7;
   localparam logic [AW-1:0] ADDR_GLB  = 4'd8;
   localparam logic [AW-1:0] ADDR_LINK = 4'd9;

   // period and compares shadowed, delays immediate
   localparam logic [NREG-1:0] MODE_RST = 7'b0011111;
endpackage

// File: rtl/psl_timebase.sv
`timescale 1ns/1ps
module psl_timebase #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] prd,
   output logic [CW-1:0] cnt,
   output logic          wrap,
   output logic          zero
);
   logic [CW-1:0] cnt_q;

   // >= keeps the counter bounded if the period shrinks immediately
   assign wrap = (cnt_q >= prd);
   assign zero = (cnt_q == '0);
   assign cnt  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (wrap) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/psl_regbank.sv
`timescale 1ns/1ps
module psl_regbank
   import psl_pkg::*;
#(
   parameter int            CW       = 16,
   parameter logic [CW-1:0] RST_PRD  = 16'd39,
   parameter logic [CW-1:0] RST_CMPA = 16'd20
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [AW-1:0]            wr_addr,
   input  logic [CW-1:0]            wr_data,
   input  logic                     peer_wr_en,
   input  logic [AW-1:0]            peer_wr_addr,
   input  logic [CW-1:0]            peer_wr_data,
   input  logic                     gload_arm,
   input  logic                     wrap,
   output logic [NREG-1:0][CW-1:0]  act,
   output logic                     armed,
   output logic                     gl_en
);
   logic [NREG-1:0] cfg_mode;
   logic [NREG-1:0] cfg_mask;
   logic [NREG-1:0] cfg_link;
   logic            cfg_gen;
   logic            armed_q;
   logic            xfer;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_mode <= MODE_RST;
         cfg_mask <= '0;
         cfg_link <= '0;
         cfg_gen  <= 1'b0;
      end else if (wr_en) begin
         case (wr_addr)
            ADDR_MODE: cfg_mode <= wr_data[NREG-1:0];
            ADDR_GLB: begin
               cfg_mask <= wr_data[NREG-1:0];
               cfg_gen  <= wr_data[NREG];
            end
            ADDR_LINK: cfg_link <= wr_data[NREG-1:0];
            default: ;
         endcase
      end
   end

   // one-shot arm: set only when enabled, cleared by the transfer itself
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       armed_q <= 1'b0;
      else if (armed_q) armed_q <= !wrap;
      else              armed_q <= gload_arm && cfg_gen;
   end

   assign xfer  = armed_q && wrap;
   assign armed = armed_q;
   assign gl_en = cfg_gen;

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      localparam logic [CW-1:0] RV = (r == IDX_PRD)  ? RST_PRD :
                                     (r == IDX_CMPA) ? RST_CMPA : '0;
      logic          own_hit;
      logic          peer_hit;
      logic          hit;
      logic          gsel;
      logic [CW-1:0] wdat;
      logic [CW-1:0] sh_q;
      logic [CW-1:0] act_q;

      assign own_hit  = wr_en && (wr_addr == AW'(r));
      assign peer_hit = peer_wr_en && (peer_wr_addr == AW'(r)) && cfg_link[r];
      assign hit      = own_hit || peer_hit;
      assign wdat     = own_hit ? wr_data : peer_wr_data;
      assign gsel     = cfg_gen && cfg_mask[r];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_q  <= RV;
            act_q <= RV;
         end else begin
            if (hit) sh_q <= wdat;
            if (gsel) begin
               if (xfer) act_q <= sh_q;
            end else if (cfg_mode[r]) begin
               if (wrap) act_q <= sh_q;
            end else if (hit) begin
               act_q <= wdat;
            end
         end
      end

      assign act[r] = act_q;
   end
endmodule

// File: rtl/psl_edge_delay.sv
`timescale 1ns/1ps
module psl_edge_delay #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sig,
   input  logic [CW-1:0] dly,
   output logic          dout
);
   logic [CW-1:0] hcnt;
   logic [CW-1:0] lat;
   logic          start;
   logic [CW-1:0] use_dly;

   // delay value is sampled at the first high clock and held for the edge
   assign start   = sig && (hcnt == '0);
   assign use_dly = start ? dly : lat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt <= '0;
         lat  <= '0;
         dout <= 1'b0;
      end else begin
         if (!sig)              hcnt <= '0;
         else if (hcnt != '1)   hcnt <= hcnt + 1'b1;
         if (start)             lat  <= dly;
         dout <= sig && (hcnt >= use_dly);
      end
   end
endmodule

// File: rtl/pwm_sync_load.sv
`timescale 1ns/1ps
module pwm_sync_load
   import psl_pkg::*;
#(
   parameter int            CW       = 16,
   parameter logic [CW-1:0] RST_PRD  = 16'd39,
   parameter logic [CW-1:0] RST_CMPA = 16'd20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [CW-1:0] wr_data,
   input  logic          peer_wr_en,
   input  logic [AW-1:0] peer_wr_addr,
   input  logic [CW-1:0] peer_wr_data,
   input  logic          gload_arm,
   output logic          pwm_a,
   output logic          pwm_b,
   output logic          zero_evt,
   output logic          load_armed
);
   localparam int NDB = 2;

   if (CW < NREG + 1) begin : g_cw_chk
      $error("CW must hold the mask plus the enable bit");
   end
   if (RST_CMPA > RST_PRD) begin : g_rst_chk
      $error("reset compare must not exceed reset period");
   end

   logic [NREG-1:0][CW-1:0] act;
   logic [CW-1:0]           cnt;
   logic [CW-1:0]           act_prd;
   logic                    wrap;
   logic                    raw;
   logic                    gl_en;
   logic [NDB-1:0]          db_sig;
   logic [NDB-1:0][CW-1:0]  db_dly;
   logic [NDB-1:0]          db_out;

   psl_regbank #(.CW(CW), .RST_PRD(RST_PRD), .RST_CMPA(RST_CMPA)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .peer_wr_en   (peer_wr_en),
      .peer_wr_addr (peer_wr_addr),
      .peer_wr_data (peer_wr_data),
      .gload_arm    (gload_arm),
      .wrap         (wrap),
      .act          (act),
      .armed        (load_armed),
      .gl_en        (gl_en)
   );

   assign act_prd = act[IDX_PRD];

   psl_timebase #(.CW(CW)) u_tb (
      .clk   (clk),
      .rst_n (rst_n),
      .prd   (act_prd),
      .cnt   (cnt),
      .wrap  (wrap),
      .zero  (zero_evt)
   );

   assign raw       = (cnt < act[IDX_CMPA]);
   assign db_sig[0] = raw;
   assign db_sig[1] = ~raw;
   assign db_dly[0] = act[IDX_RED];
   assign db_dly[1] = act[IDX_FED];

   for (genvar d = 0; d < NDB; d++) begin : g_db
      psl_edge_delay #(.CW(CW)) u_dly (
         .clk   (clk),
         .rst_n (rst_n),
         .sig   (db_sig[d]),
         .dly   (db_dly[d]),
         .dout  (db_out[d])
      );
   end

   assign pwm_a = db_out[0];
   assign pwm_b = db_out[1];
endmodule

// File: rtl/pwm_sync_load_chk.sv
`timescale 1ns/1ps
module pwm_sync_load_chk #(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          zero_evt,
   input logic          wrap,
   input logic          raw,
   input logic          pwm_a,
   input logic          pwm_b,
   input logic          load_armed,
   input logic          gl_en,
   input logic [CW-1:0] act_prd
);
   a_r1_zero_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_evt && act_prd != '0) |=> !zero_evt);

   a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> zero_evt);

   a_r2_a_low_after_raw_low: assert property (@(posedge clk) disable iff (!rst_n)
      !raw |=> !pwm_a);

   a_r3_b_low_after_raw_high: assert property (@(posedge clk) disable iff (!rst_n)
      raw |=> !pwm_b);

   a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(pwm_a && pwm_b));

   a_r9_clear_on_transfer: assert property (@(posedge clk) disable iff (!rst_n)
      (load_armed && wrap) |=> !load_armed);

   a_r9_hold_until_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (load_armed && !wrap) |=> load_armed);

   a_r13_no_arm_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_armed && !gl_en) |=> !load_armed);
endmodule

bind pwm_sync_load pwm_sync_load_chk #(.CW(CW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .zero_evt   (zero_evt),
   .wrap       (wrap),
   .raw        (raw),
   .pwm_a      (pwm_a),
   .pwm_b      (pwm_b),
   .load_armed (load_armed),
   .gl_en      (gl_en),
   .act_prd    (act_prd)
);

// File: tb/pwm_sync_load_bench.sv
`timescale 1ns/1ps
module pwm_sync_load_bench;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [3:0]    wr_addr = '0;
   logic [CW-1:0] wr_data = '0;
   logic          peer_wr_en = 1'b0;
   logic [3:0]    peer_wr_addr = '0;
   logic [CW-1:0] peer_wr_data = '0;
   logic          gload_arm = 1'b0;
   logic          pwm_a, pwm_b, zero_evt, load_armed;

   pwm_sync_load #(.CW(CW)) u_pwm_sync_load (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .peer_wr_en(peer_wr_en), .peer_wr_addr(peer_wr_addr), .peer_wr_data(peer_wr_data),
      .gload_arm(gload_arm),
      .pwm_a(pwm_a), .pwm_b(pwm_b), .zero_evt(zero_evt), .load_armed(load_armed)
   );

   always #4 clk = ~clk;

   typedef struct {
      int    tgt;
      int    len;
      int    ar;
      int    af;
      int    br;
      string req;
   } exp_t;

   exp_t q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   int   cur   = -1;
   int   last  = -1;

   task automatic push(input int tgt, input int prd, input int cmpa,
                       input int red, input int fed, input string req);
      exp_t e;
      e.tgt = tgt; e.len = prd + 1; e.ar = red + 1;
      e.af = cmpa + 1; e.br = cmpa + 1 + fed; e.req = req;
      q.push_back(e);
      if (tgt > last) last = tgt;
   endtask

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic sync_zero(output int k);
      do @(negedge clk); while (!zero_evt);
      #1;
      k = cur;
   endtask

   task automatic sync_after(output int k);
      do sync_zero(k); while (k <= last);
   endtask

   task automatic wr(input logic [3:0] a, input int d);
      wr_en = 1'b1; wr_addr = a; wr_data = CW'(d);
      @(negedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic peer(input logic [3:0] a, input int d);
      peer_wr_en = 1'b1; peer_wr_addr = a; peer_wr_data = CW'(d);
      @(negedge clk); #1;
      peer_wr_en = 1'b0;
   endtask

   task automatic arm();
      gload_arm = 1'b1;
      @(negedge clk); #1;
      gload_arm = 1'b0;
   endtask

   // monitor: measures each cycle and compares with the queue front
   initial begin
      int len, ar, af, br;
      logic pa, pb;
      pa = 1'b0; pb = 1'b0; len = 0; ar = -1; af = -1; br = -1;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         if (zero_evt) begin
            if (cur >= 0 && q.size() != 0) begin
               if (q[0].tgt == cur) begin
                  exp_t e;
                  e = q.pop_front();
                  n_cmp++;
                  if (len != e.len || ar != e.ar || af != e.af || br != e.br) begin
                     n_bad++;
                     $display("FAIL %s cycle %0d actual len/a_rise/a_fall/b_rise=%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d",
                              e.req, cur, len, ar, af, br, e.len, e.ar, e.af, e.br);
                  end
               end else if (q[0].tgt < cur) begin
                  exp_t e;
                  e = q.pop_front();
                  n_cmp++; n_bad++;
                  $display("FAIL %s cycle %0d actual=missed expected=compared", e.req, e.tgt);
               end
            end
            cur++;
            len = 0; ar = -1; af = -1; br = -1;
         end
         if (pwm_a && !pa && ar < 0) ar = len;
         if (!pwm_a && pa && af < 0) af = len;
         if (pwm_b && !pb && br < 0) br = len;
         pa = pwm_a; pb = pwm_b;
         len++;
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int k;
      // R1 R2 R3: reset defaults, period 39, compare 20, delays 0
      push(0, 39, 20, 0, 0, "R1_R2_R3 default");
      push(1, 39, 20, 0, 0, "R1_R2_R3 default");
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 zero at reset", int'(zero_evt), 1);
      check("R2 pwm_a at reset", int'(pwm_a), 0);
      check("R3 pwm_b at reset", int'(pwm_b), 0);
      check("R1 armed at reset", int'(load_armed), 0);

      // R4: shadow period and compare apply from the next cycle
      sync_after(k);
      wr(4'd0, 29); wr(4'd1, 12);
      push(k,     39, 20, 0, 0, "R4 before load");
      push(k + 1, 29, 12, 0, 0, "R4 after load");

      // R5 R6: delays immediate out of reset; running rise keeps old value
      sync_after(k);
      wr(4'd5, 5); wr(4'd6, 3);
      push(k,     29, 12, 0, 3, "R5_R6 same cycle");
      push(k + 1, 29, 12, 5, 3, "R6 next cycle");

      // R7 R11: global on, mask period+rise, no arm
      sync_after(k);
      wr(4'd8, 'hA1); wr(4'd0, 25); wr(4'd5, 2); wr(4'd1, 10);
      push(k,     29, 12, 5, 3, "R7 masked held");
      push(k + 1, 29, 10, 5, 3, "R11 unmasked compare loads");
      push(k + 2, 29, 10, 5, 3, "R7 no arm no load");
      check("R7 armed without arm", int'(load_armed), 0);

      // R8 R9 R10: arm, double arm, latest value transferred together
      sync_after(k);
      wr(4'd0, 33);
      arm();
      check("R8 armed after arm", int'(load_armed), 1);
      arm();
      push(k,     29, 10, 5, 3, "R8 before transfer");
      push(k + 1, 33, 10, 2, 3, "R8_R10 joint transfer");
      push(k + 2, 33, 10, 2, 3, "R9 no second transfer");
      sync_zero(k);
      check("R9 armed cleared at transfer", int'(load_armed), 0);
      wr(4'd0, 21);

      // R13: disable global, arm ignored; pending shadow loads normally
      sync_after(k);
      wr(4'd8, 0);
      arm();
      check("R13 arm ignored when disabled", int'(load_armed), 0);
      push(k,     33, 10, 2, 3, "R13 before");
      push(k + 1, 21, 10, 2, 3, "R13 shadow mode resumes");

      // R12: link compare A only; local write wins a same-clock collision
      sync_after(k);
      wr(4'd9, 'h02);
      peer(4'd0, 35);
      peer(4'd1, 15);
      wr_en = 1'b1; wr_addr = 4'd1; wr_data = CW'(16);
      peer_wr_en = 1'b1; peer_wr_addr = 4'd1; peer_wr_data = CW'(17);
      @(negedge clk); #1;
      wr_en = 1'b0; peer_wr_en = 1'b0;
      push(k,     21, 10, 2, 3, "R12 before");
      push(k + 1, 21, 16, 2, 3, "R12 link and priority");

      while (q.size() != 0) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule